// File: doc/BRIEF.md
# Gap-Aligned Clocked Frame Sniffer

This block listens, without ever driving anything, to a two-wire link made of a bus clock and a bus data line. It recovers the fixed-length frames that a master controller sends. A fast system clock oversamples both wires through synchroniser chains. One data bit is taken at each detected rising edge of the bus clock, and the bits are assembled into bytes. The data line is allowed to move freely while the bus clock is low, and the block ignores those movements. An undriven data line reads as 0.

The link has no start or stop signalling. All alignment therefore comes from how long the bus clock stays low. A short idle stretch separates bytes, and a partial byte left open at that point is thrown away and flagged. A much longer idle stretch separates frames, and it returns the byte index to zero. Each finished byte is reported together with its position in the frame. A strobe marks the last byte of a frame, a frame-length error is flagged, and one byte chosen by a select input is held in a register so a host can read it at any time.

Top module: `clkdata_frame_sniffer`

## Requirements
- R1: After reset, every output is 0: `byte_valid_o`, `byte_data_o`, `byte_idx_o`, `frame_done_o`, `sel_byte_o`, `frame_err_o` and `partial_err_o`.
- R2: The data bit is sampled only at a rising edge of the synchronised bus clock. With the default `LSB_FIRST`=0, the first bit received becomes bit 7. After every `BYTE_W` bits, `byte_valid_o` pulses for exactly one cycle with the byte on `byte_data_o`. Changes on the data line while the bus clock is low have no effect.
- R3: With `LSB_FIRST`=1, the first bit received becomes bit 0. The reported byte is then the bit reversal of the byte reported with `LSB_FIRST`=0 for the same wire traffic.
- R4: `byte_idx_o` gives the byte's position in the frame. The first byte after a frame gap is 0, each following byte adds one, and the value never exceeds `FRAME_BYTES`.
- R5: `frame_done_o` pulses for one cycle, together with `byte_valid_o`, when the byte at index `FRAME_BYTES`-1 is reported.
- R6: `sel_byte_o` takes the value of the reported byte whose index equals `sel_idx_i` (range 0 to `FRAME_BYTES`-1). It keeps that value until another byte matches.
- R7: If the bus clock stays low for more than `BYTE_GAP_CYC` cycles while a byte is partly received, the partial bits are discarded and `partial_err_o` pulses for one cycle. The next bit then starts a new byte.
- R8: If the bus clock stays low for more than `FRAME_GAP_CYC` cycles, the next byte is reported with index 0.
- R9: `frame_err_o` pulses when a frame gap ends a frame that holds 1 to `FRAME_BYTES`-1 bytes.
- R10: A byte that arrives after `FRAME_BYTES` bytes, with no frame gap in between, is reported with index `FRAME_BYTES` and raises `frame_err_o` in the same cycle.
- R11: A byte gap with no bits pending gives no `partial_err_o`. A frame gap after zero bytes or after exactly `FRAME_BYTES` bytes gives no `frame_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_clk_i | input | 1 | Sniffed bus clock wire |
| bus_data_i | input | 1 | Sniffed bus data wire |
| sel_idx_i | input | $clog2(FRAME_BYTES+1) | Index of the byte to hold on `sel_byte_o` |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_data_o | output | BYTE_W | Completed byte |
| byte_idx_o | output | $clog2(FRAME_BYTES+1) | Position of the byte in its frame |
| frame_done_o | output | 1 | Strobe with the last byte of a frame |
| sel_byte_o | output | BYTE_W | Held copy of the selected byte |
| frame_err_o | output | 1 | Strobe for a short or overlong frame |
| partial_err_o | output | 1 | Strobe for a discarded partial byte |

## Verification
The bench builds two copies of the block on the same wires. Both use `BYTE_GAP_CYC`=20 and `FRAME_GAP_CYC`=60; one has MSB-first order and the other LSB-first. The short thresholds let byte gaps, frame gaps, short frames, overlong frames and dropped partial bytes all happen within a few thousand cycles. The second copy checks bit order directly against the first traffic. Data noise is injected during every low phase of the bus clock, so the rule of sampling only at the rising edge is exercised on every bit.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
  localparam int unsigned MAX_BYTE_W = 32;

  // Insert one received bit into a shift register of width w.
  function automatic logic [MAX_BYTE_W-1:0] shift_in(
    input logic [MAX_BYTE_W-1:0] sh,
    input logic                  b,
    input int unsigned           w,
    input logic                  lsb_first
  );
    logic [MAX_BYTE_W-1:0] bw;
    bw = {{(MAX_BYTE_W-1){1'b0}}, b};
    if (lsb_first) return (sh >> 1) | (bw << (w - 1));
    else           return (sh << 1) | bw;
  endfunction

  // True in the cycle a low-time count has passed a limit.
  function automatic logic at_limit(input logic [31:0] cnt, input int unsigned lim);
    return cnt == lim;
  endfunction
endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/sniff_gap_timer.sv
module sniff_gap_timer
  import sniff_pkg::*;
#(
  parameter int unsigned BYTE_GAP_CYC  = 5000,
  parameter int unsigned FRAME_GAP_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_low_i,
  output logic byte_gap_o,
  output logic frame_gap_o
);
  localparam int unsigned CW  = $clog2(FRAME_GAP_CYC + 2);
  localparam int unsigned SAT = FRAME_GAP_CYC + 1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= '0;
    else if (!line_low_i)            low_cnt <= '0;
    else if (low_cnt != CW'(SAT))    low_cnt <= low_cnt + 1'b1;
  end

  assign byte_gap_o  = line_low_i && at_limit(32'(low_cnt), BYTE_GAP_CYC);
  assign frame_gap_o = line_low_i && at_limit(32'(low_cnt), FRAME_GAP_CYC);
endmodule

// File: rtl/sniff_byte_asm.sv
module sniff_byte_asm
  import sniff_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              flush_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              drop_o
);
  localparam int BCW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [BCW-1:0]    bit_cnt;
  logic [BYTE_W-1:0] nxt;

  assign nxt = BYTE_W'(shift_in(MAX_BYTE_W'(sh), bit_i, BYTE_W, LSB_FIRST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
      done_o  <= 1'b0;
      data_o  <= '0;
      drop_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      drop_o <= 1'b0;
      if (rise_i) begin
        if (bit_cnt == BCW'(BYTE_W - 1)) begin
          bit_cnt <= '0;
          sh      <= '0;
          done_o  <= 1'b1;
          data_o  <= nxt;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= nxt;
        end
      end else if (flush_i) begin
        if (bit_cnt != '0) drop_o <= 1'b1;
        bit_cnt <= '0;
        sh      <= '0;
      end
    end
  end
endmodule

// File: rtl/sniff_frame_trk.sv
module sniff_frame_trk #(
  parameter int BYTE_W      = 8,
  parameter int FRAME_BYTES = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               byte_done_i,
  input  logic [BYTE_W-1:0]                  byte_i,
  input  logic                               frame_gap_i,
  input  logic [$clog2(FRAME_BYTES+1)-1:0]   sel_idx_i,
  output logic                               byte_valid_o,
  output logic [BYTE_W-1:0]                  byte_data_o,
  output logic [$clog2(FRAME_BYTES+1)-1:0]   byte_idx_o,
  output logic                               frame_done_o,
  output logic [BYTE_W-1:0]                  sel_byte_o,
  output logic                               frame_err_o
);
  localparam int IW = $clog2(FRAME_BYTES + 1);
  localparam logic [IW-1:0] FULL = IW'(FRAME_BYTES);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BYTES - 1);

  logic [IW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      byte_idx_o   <= '0;
      frame_done_o <= 1'b0;
      sel_byte_o   <= '0;
      frame_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      frame_done_o <= 1'b0;
      frame_err_o  <= 1'b0;
      if (byte_done_i) begin
        byte_valid_o <= 1'b1;
        byte_data_o  <= byte_i;
        byte_idx_o   <= cnt;
        if (cnt == FULL) begin
          frame_err_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST)      frame_done_o <= 1'b1;
          if (cnt == sel_idx_i) sel_byte_o   <= byte_i;
        end
      end else if (frame_gap_i) begin
        if (cnt != '0 && cnt != FULL) frame_err_o <= 1'b1;
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/clkdata_frame_sniffer.sv
module clkdata_frame_sniffer #(
  parameter int          BYTE_W        = 8,
  parameter int          FRAME_BYTES   = 6,
  parameter int unsigned BYTE_GAP_CYC  = 5000,
  parameter int unsigned FRAME_GAP_CYC = 500000,
  parameter bit          LSB_FIRST     = 1'b0,
  parameter int          SYNC_STAGES   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_clk_i,
  input  logic                             bus_data_i,
  input  logic [$clog2(FRAME_BYTES+1)-1:0] sel_idx_i,
  output logic                             byte_valid_o,
  output logic [BYTE_W-1:0]                byte_data_o,
  output logic [$clog2(FRAME_BYTES+1)-1:0] byte_idx_o,
  output logic                             frame_done_o,
  output logic [BYTE_W-1:0]                sel_byte_o,
  output logic                             frame_err_o,
  output logic                             partial_err_o
);
  logic [1:0]        sync_q;
  logic              clk_s, dat_s, clk_d;
  logic              rise_w, byte_gap_w, frame_gap_w, byte_done_w;
  logic [BYTE_W-1:0] asm_byte_w;

  sniff_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({bus_data_i, bus_clk_i}), .q_o(sync_q)
  );
  assign clk_s = sync_q[0];
  assign dat_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_d <= 1'b0;
    else        clk_d <= clk_s;
  end
  assign rise_w = clk_s & ~clk_d;

  sniff_gap_timer #(.BYTE_GAP_CYC(BYTE_GAP_CYC), .FRAME_GAP_CYC(FRAME_GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .line_low_i(~clk_s),
    .byte_gap_o(byte_gap_w), .frame_gap_o(frame_gap_w)
  );

  sniff_byte_asm #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_asm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .bit_i(dat_s), .flush_i(byte_gap_w),
    .done_o(byte_done_w), .data_o(asm_byte_w), .drop_o(partial_err_o)
  );

  sniff_frame_trk #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_trk (
    .clk(clk), .rst_n(rst_n), .byte_done_i(byte_done_w), .byte_i(asm_byte_w),
    .frame_gap_i(frame_gap_w), .sel_idx_i(sel_idx_i),
    .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o), .byte_idx_o(byte_idx_o),
    .frame_done_o(frame_done_o), .sel_byte_o(sel_byte_o), .frame_err_o(frame_err_o)
  );
endmodule

// File: rtl/sniff_checker.sv
module sniff_checker #(
  parameter int BYTE_W      = 8,
  parameter int FRAME_BYTES = 6
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             byte_valid_o,
  input logic [BYTE_W-1:0]                byte_data_o,
  input logic [$clog2(FRAME_BYTES+1)-1:0] byte_idx_o,
  input logic                             frame_done_o,
  input logic [BYTE_W-1:0]                sel_byte_o,
  input logic                             frame_err_o,
  input logic                             partial_err_o,
  input logic                             byte_gap_w,
  input logic                             frame_gap_w
);
  localparam int IW = $clog2(FRAME_BYTES + 1);

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> byte_idx_o <= IW'(FRAME_BYTES));

  assert_done_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> byte_valid_o && byte_idx_o == IW'(FRAME_BYTES - 1));

  assert_sel_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_byte_o) |-> byte_valid_o && sel_byte_o == byte_data_o);

  assert_drop_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    partial_err_o |-> $past(byte_gap_w));

  assert_short_frame_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_o && !byte_valid_o) |-> $past(frame_gap_w));

  assert_errors_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err_o && partial_err_o));

  assert_overflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && byte_idx_o == IW'(FRAME_BYTES)) |-> frame_err_o);
endmodule

bind clkdata_frame_sniffer sniff_checker #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
  .byte_idx_o(byte_idx_o), .frame_done_o(frame_done_o), .sel_byte_o(sel_byte_o),
  .frame_err_o(frame_err_o), .partial_err_o(partial_err_o),
  .byte_gap_w(byte_gap_w), .frame_gap_w(frame_gap_w)
);

// File: tb/sim_clkdata_frame_sniffer.sv
module sim_clkdata_frame_sniffer;
  localparam int NB = 6;
  localparam int IW = $clog2(NB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0;
  logic bdat = 1'b0;
  logic [IW-1:0] sel = '0;
  always #2 clk = ~clk;

  logic v0, fd0, fe0, pe0, v1, fd1, fe1, pe1;
  logic [7:0] d0, s0, d1, s1;
  logic [IW-1:0] i0, i1;

  clkdata_frame_sniffer #(.BYTE_GAP_CYC(20), .FRAME_GAP_CYC(60), .LSB_FIRST(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_data_i(bdat), .sel_idx_i(sel),
    .byte_valid_o(v0), .byte_data_o(d0), .byte_idx_o(i0), .frame_done_o(fd0),
    .sel_byte_o(s0), .frame_err_o(fe0), .partial_err_o(pe0));

  clkdata_frame_sniffer #(.BYTE_GAP_CYC(20), .FRAME_GAP_CYC(60), .LSB_FIRST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_data_i(bdat), .sel_idx_i(sel),
    .byte_valid_o(v1), .byte_data_o(d1), .byte_idx_o(i1), .frame_done_o(fd1),
    .sel_byte_o(s1), .frame_err_o(fe1), .partial_err_o(pe1));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] q0[$], q1[$];
  int unsigned qi[$], qj[$];
  int n_done = 0, n_ferr = 0, n_perr = 0;
  logic [7:0] frame_buf [NB+1];

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = b[7-k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitors: compare every reported byte against the expected queues.
  always @(negedge clk) if (rst_n) begin
    if (v0) begin
      if (q0.size() == 0) chk(0, "R2 unexpected byte", d0, 0);
      else begin
        logic [7:0] e; int unsigned ix;
        e = q0.pop_front(); ix = qi.pop_front();
        chk(d0 == e, "R2 byte data", d0, e);
        chk(i0 == IW'(ix), "R4 byte index", i0, ix);
        chk(fd0 == (ix == NB - 1), "R5 frame_done with last byte", fd0, ix == NB - 1);
        if (ix == NB) chk(fe0, "R10 overflow error", fe0, 1);
      end
    end
    if (v1) begin
      if (q1.size() == 0) chk(0, "R3 unexpected byte", d1, 0);
      else begin
        logic [7:0] e; int unsigned ix;
        e = q1.pop_front(); ix = qj.pop_front();
        chk(d1 == e, "R3 lsb-first data", d1, e);
        chk(i1 == IW'(ix), "R4 index lsb copy", i1, ix);
      end
    end
    if (fd0) n_done++;
    if (fe0) n_ferr++;
    if (pe0) n_perr++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus bit: noise on data while clock low, then settle and pulse.
  task automatic send_bit(input logic b);
    bdat = 1'($urandom); cyc(1);
    bdat = 1'($urandom); cyc(1);
    bdat = b;            cyc(2);
    bclk = 1'b1;         cyc(4);
    bclk = 1'b0;
    bdat = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int unsigned idx);
    q0.push_back(b); qi.push_back(idx);
    q1.push_back(rev8(b)); qj.push_back(idx);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
  endtask

  task automatic byte_gap();
    cyc(30);
  endtask

  task automatic frame_gap();
    cyc(90);
  endtask

  task automatic queues_empty(input string req);
    chk(q0.size() == 0 && q1.size() == 0, req, q0.size(), 0);
  endtask

  task automatic full_frame(input int unsigned s);
    int dn, fe, pe;
    dn = n_done; fe = n_ferr; pe = n_perr;
    sel = IW'(s);
    for (int k = 0; k < NB; k++) begin
      send_byte(frame_buf[k], k);
      byte_gap();
    end
    frame_gap();
    queues_empty("R2 all bytes reported");
    chk(n_done == dn + 1, "R5 one frame_done", n_done - dn, 1);
    chk(n_ferr == fe, "R11 no frame error on full frame", n_ferr - fe, 0);
    chk(n_perr == pe, "R11 no partial error on clean gaps", n_perr - pe, 0);
    chk(s0 == frame_buf[s], "R6 selected byte", s0, frame_buf[s]);
    chk(s1 == rev8(frame_buf[s]), "R3 selected byte lsb copy", s1, rev8(frame_buf[s]));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    cyc(3);
    chk({v0, d0, i0, fd0, s0, fe0, pe0} == '0, "R1 reset outputs u0", d0, 0);
    chk({v1, d1, i1, fd1, s1, fe1, pe1} == '0, "R1 reset outputs u1", d1, 0);
    rst_n = 1'b1;
    frame_gap();
    chk(n_ferr == 0 && n_perr == 0, "R11 idle gaps raise nothing", n_ferr + n_perr, 0);

    // Directed frame with edge patterns.
    frame_buf[0] = 8'hA5; frame_buf[1] = 8'h3C; frame_buf[2] = 8'hFF;
    frame_buf[3] = 8'h00; frame_buf[4] = 8'h81; frame_buf[5] = 8'h7E;
    full_frame(2);

    // Random frames.
    for (int f = 0; f < 10; f++) begin
      for (int k = 0; k < NB; k++) frame_buf[k] = 8'($urandom);
      full_frame($urandom_range(0, NB - 1));
    end

    // R7: partial byte in the middle of a frame is dropped.
    begin
      int pe, dn;
      pe = n_perr; dn = n_done;
      for (int k = 0; k < NB; k++) frame_buf[k] = 8'($urandom);
      sel = IW'(4);
      send_byte(frame_buf[0], 0); byte_gap();
      send_byte(frame_buf[1], 1); byte_gap();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      byte_gap();
      chk(n_perr == pe + 1, "R7 partial byte flagged", n_perr - pe, 1);
      for (int k = 2; k < NB; k++) begin
        send_byte(frame_buf[k], k); byte_gap();
      end
      frame_gap();
      queues_empty("R7 bytes after drop realigned");
      chk(n_done == dn + 1, "R7 frame still completes", n_done - dn, 1);
      chk(s0 == frame_buf[4], "R6 selected after drop", s0, frame_buf[4]);
    end

    // R9 / R6 hold: short frame, selected index never reached.
    begin
      int fe, dn;
      logic [7:0] held;
      held = s0; fe = n_ferr; dn = n_done;
      sel = IW'(5);
      for (int k = 0; k < 3; k++) begin
        send_byte(8'($urandom), k); byte_gap();
      end
      frame_gap();
      chk(n_ferr == fe + 1, "R9 short frame error", n_ferr - fe, 1);
      chk(n_done == dn, "R9 no frame_done on short frame", n_done - dn, 0);
      chk(s0 == held, "R6 selected byte held", s0, held);
    end

    // R8: frame after a short one restarts at index 0.
    for (int k = 0; k < NB; k++) frame_buf[k] = 8'($urandom);
    full_frame(0);

    // R10: seventh byte before frame gap.
    begin
      int fe, dn;
      fe = n_ferr; dn = n_done;
      for (int k = 0; k <= NB; k++) begin
        send_byte(8'($urandom), k); byte_gap();
      end
      frame_gap();
      queues_empty("R10 overflow byte reported");
      chk(n_ferr == fe + 1, "R10 one overflow error", n_ferr - fe, 1);
      chk(n_done == dn + 1, "R10 frame_done still on sixth", n_done - dn, 1);
    end

    // R8: index restarts after overflow frame.
    for (int k = 0; k < NB; k++) frame_buf[k] = 8'($urandom);
    full_frame(NB - 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule